// File: doc/BRIEF.md
# Single-Cycle 16-Bit Register Processor

This block is a small processor that completes one instruction per clock. Each cycle it presents a byte address on its code port, takes the 16-bit instruction word that comes back and executes it before the next edge. Instruction and data memories are outside the block. The data side has an address output, a write-data output, a read-data input and a write strobe. The memories must answer within the same cycle.

The register file has sixteen 16-bit entries. Entry 14 is the program counter, and the code address is always that register's value. Every register-writing instruction can therefore also steer control flow. The block executes six instruction kinds: immediate set, add, compare, memory load, memory store and a conditional relative branch. Any other opcode is an empty step.

An instruction word splits into four nibbles. Bits [15:12] hold the opcode. Bits [11:8] name the destination register, or the first operand. Bits [7:4] and [3:0] name further operands. For the set and branch instructions, bits [7:0] hold an 8-bit immediate.

Top module: `cpu16_core`

## Requirements
- R1: While `rst` is high at a clock edge, every register (including the program counter) and the equal flag are cleared. `code_addr` reads 0x0000 in the cycle after that edge.
- R2: Opcode 0x2 (store), opcode 0xC (compare) and every opcode outside {0x1, 0x2, 0x3, 0xC, 0xD, 0xE} advance `code_addr` by exactly 2. Opcode 0x0 and the unused opcodes write no register and do not raise `wr_en`.
- R3: Opcode 0xE (set) writes bits [7:0], zero-extended to 16 bits, into the register selected by bits [11:8].
- R4: A set whose bits [11:8] equal 14 is an absolute jump. In the next cycle, `code_addr` equals the zero-extended bits [7:0].
- R5: Opcode 0x2 (store) drives `data_addr` with the register selected by bits [7:4] and drives `wr_data` with the register selected by bits [11:8]. `wr_en` is high in exactly the cycles whose instruction has opcode 0x2.
- R6: Opcode 0x1 (load) drives `data_addr` with the register selected by bits [7:4] and keeps `wr_en` low. At the clock edge it writes `rd_data` into the register selected by bits [11:8].
- R7: Opcode 0x3 (add) writes the sum modulo 2^16 of the registers selected by bits [7:4] and [3:0] into the register selected by bits [11:8].
- R8: Opcode 0xC (compare) sets the equal flag when the register selected by bits [11:8] equals the register selected by bits [7:4], and clears it otherwise. It writes no register. The flag keeps its value through all other opcodes.
- R9: Opcode 0xD (branch) adds the sign-extended bits [7:0] to the branch's own address when the equal flag is set. When the flag is clear, it advances by 2.
- R10: When a set, add or load names register 14 as its destination, the written value becomes the next `code_addr` in place of the step of 2.
- R11: An operand field that selects register 14 reads the address of the instruction being executed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| code_data | input | 16 | Instruction word at `code_addr` |
| code_addr | output | 16 | Byte address of the current instruction (register 14) |
| data_addr | output | 16 | Data memory address for load and store |
| wr_data | output | 16 | Data to be written by a store |
| rd_data | input | 16 | Data memory word at `data_addr` |
| wr_en | output | 1 | Data write strobe, high during a store |

## Verification
Two things can land on the program counter in the same cycle: the normal step of 2, and a register write whose destination is register 14 (a set, add or load). Reading register 14 as an operand while it is advancing belongs to the same collision.

Directed programs provoke these cases:
- a load from memory into register 14;
- an add into register 14;
- an add that reads register 14 as an operand.

Random programs repeat them at arbitrary points, alongside branches whose flag comes from a compare in the previous cycle.

The bench judges each case with its own instruction-level model. The model predicts the next code address and the data-port values for every cycle, and these are compared at the falling edge.

// File: rtl/cpu16_pkg.sv
package cpu16_pkg;

   localparam int unsigned INSTR_W = 16;
   localparam int unsigned FIELD_W = 4;
   localparam int unsigned IMM_W   = 8;

   typedef enum logic [FIELD_W-1:0] {
      OP_NOP   = 4'h0,
      OP_LOAD  = 4'h1,
      OP_STORE = 4'h2,
      OP_ADD   = 4'h3,
      OP_CMP   = 4'hC,
      OP_BEQ   = 4'hD,
      OP_SET   = 4'hE
   } opcode_e;

   typedef struct packed {
      logic [FIELD_W-1:0] dst;
      logic [FIELD_W-1:0] srca;
      logic [FIELD_W-1:0] srcb;
      logic [IMM_W-1:0]   imm;
      logic               is_set;
      logic               is_load;
      logic               is_store;
      logic               is_add;
      logic               is_cmp;
      logic               is_beq;
   } dec_t;

endpackage

// File: rtl/cpu16_decode.sv
module cpu16_decode
   import cpu16_pkg::*;
(
   input  logic [INSTR_W-1:0] instr,
   output dec_t               dec
);

   always_comb begin
      dec          = '0;
      dec.dst      = instr[11:8];
      dec.srca     = instr[7:4];
      dec.srcb     = instr[3:0];
      dec.imm      = instr[7:0];
      case (instr[15:12])
         OP_SET:   dec.is_set   = 1'b1;
         OP_LOAD:  dec.is_load  = 1'b1;
         OP_STORE: dec.is_store = 1'b1;
         OP_ADD:   dec.is_add   = 1'b1;
         OP_CMP:   dec.is_cmp   = 1'b1;
         OP_BEQ:   dec.is_beq   = 1'b1;
         default:  ;
      endcase
   end

endmodule

// File: rtl/cpu16_regfile.sv
module cpu16_regfile #(
   parameter int unsigned XLEN   = 16,
   parameter int unsigned NREG   = 16,
   parameter int unsigned PC_REG = 14,
   localparam int unsigned SEL_W = $clog2(NREG)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [SEL_W-1:0] sel_d,
   input  logic [SEL_W-1:0] sel_a,
   input  logic [SEL_W-1:0] sel_b,
   input  logic             we,
   input  logic [XLEN-1:0]  wdata,
   input  logic [XLEN-1:0]  pc_next,
   output logic [XLEN-1:0]  val_d,
   output logic [XLEN-1:0]  val_a,
   output logic [XLEN-1:0]  val_b,
   output logic [XLEN-1:0]  pc
);

   logic [NREG-1:0][XLEN-1:0] q;

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      localparam logic [SEL_W-1:0] IDX = SEL_W'(g);
      logic [XLEN-1:0] r;
      if (g == PC_REG) begin : g_pc
         always_ff @(posedge clk) begin
            if (rst) r <= '0;
            else     r <= pc_next;
         end
      end else begin : g_gp
         always_ff @(posedge clk) begin
            if (rst)                   r <= '0;
            else if (we && sel_d == IDX) r <= wdata;
         end
      end
      assign q[g] = r;
   end

   assign val_d = q[sel_d];
   assign val_a = q[sel_a];
   assign val_b = q[sel_b];
   assign pc    = q[PC_REG];

endmodule

// File: rtl/cpu16_alu.sv
module cpu16_alu #(
   parameter int unsigned XLEN    = 16,
   parameter int unsigned PC_STEP = 2
) (
   input  logic [XLEN-1:0] val_d,
   input  logic [XLEN-1:0] val_a,
   input  logic [XLEN-1:0] val_b,
   input  logic [XLEN-1:0] pc,
   input  logic [7:0]      imm,
   output logic [XLEN-1:0] sum,
   output logic            equal,
   output logic [XLEN-1:0] pc_seq,
   output logic [XLEN-1:0] pc_rel,
   output logic [XLEN-1:0] imm_zx
);

   localparam int unsigned EXT_W = XLEN - 8;

   assign sum    = val_a + val_b;
   assign equal  = (val_d == val_a);
   assign pc_seq = pc + XLEN'(PC_STEP);
   assign pc_rel = pc + {{EXT_W{imm[7]}}, imm};
   assign imm_zx = {{EXT_W{1'b0}}, imm};

endmodule

// File: rtl/cpu16_core.sv
module cpu16_core
   import cpu16_pkg::*;
#(
   parameter int unsigned XLEN    = 16,
   parameter int unsigned NREG    = 16,
   parameter int unsigned PC_REG  = 14,
   parameter int unsigned PC_STEP = 2
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [INSTR_W-1:0] code_data,
   output logic [XLEN-1:0]    code_addr,
   output logic [XLEN-1:0]    data_addr,
   output logic [XLEN-1:0]    wr_data,
   input  logic [XLEN-1:0]    rd_data,
   output logic               wr_en
);

   localparam int unsigned SEL_W = $clog2(NREG);
   localparam logic [SEL_W-1:0] PC_IDX = SEL_W'(PC_REG);

   if (NREG != (1 << FIELD_W)) begin : g_bad_nreg
      $error("NREG must match the 4-bit register fields");
   end
   if (PC_REG >= NREG) begin : g_bad_pc
      $error("PC_REG must name an existing register");
   end
   if (XLEN < INSTR_W) begin : g_bad_xlen
      $error("XLEN must be at least the instruction width");
   end
   if (PC_STEP == 0) begin : g_bad_step
      $error("PC_STEP must be non-zero");
   end

   dec_t            dec;
   logic [XLEN-1:0] val_d, val_a, val_b, pc;
   logic [XLEN-1:0] sum, pc_seq, pc_rel, imm_zx;
   logic            equal;
   logic            eq_flag;
   logic            rf_we;
   logic [XLEN-1:0] rf_wdata;
   logic [XLEN-1:0] pc_next;

   cpu16_decode u_dec (
      .instr (code_data),
      .dec   (dec)
   );

   cpu16_regfile #(
      .XLEN   (XLEN),
      .NREG   (NREG),
      .PC_REG (PC_REG)
   ) u_rf (
      .clk     (clk),
      .rst     (rst),
      .sel_d   (dec.dst),
      .sel_a   (dec.srca),
      .sel_b   (dec.srcb),
      .we      (rf_we),
      .wdata   (rf_wdata),
      .pc_next (pc_next),
      .val_d   (val_d),
      .val_a   (val_a),
      .val_b   (val_b),
      .pc      (pc)
   );

   cpu16_alu #(
      .XLEN    (XLEN),
      .PC_STEP (PC_STEP)
   ) u_alu (
      .val_d  (val_d),
      .val_a  (val_a),
      .val_b  (val_b),
      .pc     (pc),
      .imm    (dec.imm),
      .sum    (sum),
      .equal  (equal),
      .pc_seq (pc_seq),
      .pc_rel (pc_rel),
      .imm_zx (imm_zx)
   );

   always_ff @(posedge clk) begin
      if (rst)             eq_flag <= 1'b0;
      else if (dec.is_cmp) eq_flag <= equal;
   end

   assign rf_we = dec.is_set | dec.is_add | dec.is_load;

   always_comb begin
      rf_wdata = imm_zx;
      if (dec.is_add)  rf_wdata = sum;
      if (dec.is_load) rf_wdata = rd_data;
   end

   always_comb begin
      if (rf_we && dec.dst == PC_IDX)  pc_next = rf_wdata;
      else if (dec.is_beq && eq_flag) pc_next = pc_rel;
      else                            pc_next = pc_seq;
   end

   assign code_addr = pc;
   assign data_addr = val_a;
   assign wr_data   = val_d;
   assign wr_en     = dec.is_store;

endmodule

// File: rtl/cpu16_core_chk.sv
module cpu16_core_chk #(
   parameter int unsigned XLEN = 16
) (
   input logic            clk,
   input logic            rst,
   input logic [15:0]     code_data,
   input logic [XLEN-1:0] code_addr,
   input logic            wr_en
);

   logic [3:0] op;
   assign op = code_data[15:12];

   assert_reset_addr_R1: assert property (@(posedge clk)
      rst |=> (code_addr == '0));

   assert_plain_step_R2: assert property (@(posedge clk) disable iff (rst)
      (op == 4'h0 || op == 4'h2 || op == 4'hC || (op >= 4'h4 && op <= 4'hB) || op == 4'hF)
      |=> (code_addr == $past(code_addr) + XLEN'(2)));

   assert_set_jump_R4: assert property (@(posedge clk) disable iff (rst)
      (code_data[15:8] == 8'hEE)
      |=> (code_addr == XLEN'($past(code_data[7:0]))));

   assert_store_strobe_R5: assert property (@(posedge clk) disable iff (rst)
      wr_en |-> (op == 4'h2));

   assert_store_raises_R5: assert property (@(posedge clk) disable iff (rst)
      (op == 4'h2) |-> wr_en);

   assert_load_no_write_R6: assert property (@(posedge clk) disable iff (rst)
      (op == 4'h1) |-> !wr_en);

endmodule

bind cpu16_core cpu16_core_chk #(.XLEN(XLEN)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .code_data (code_data),
   .code_addr (code_addr),
   .wr_en     (wr_en)
);

// File: tb/cpu16_core_tb_top.sv
module cpu16_core_tb_top;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [15:0] code_addr, code_data, data_addr, wr_data, rd_data;
   logic        wr_en;

   logic [15:0] rom  [64];
   logic [15:0] dmem [256];

   // reference model state
   logic [15:0] mr   [16];
   logic [15:0] mdm  [256];
   logic        mflag;
   string       pc_tag;
   string       st_tag;

   int n_run  = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   cpu16_core dut_i (
      .clk       (clk),
      .rst       (rst),
      .code_data (code_data),
      .code_addr (code_addr),
      .data_addr (data_addr),
      .wr_data   (wr_data),
      .rd_data   (rd_data),
      .wr_en     (wr_en)
   );

   assign code_data = rom[code_addr[6:1]];
   assign rd_data   = dmem[data_addr[7:0]];

   always @(posedge clk) if (wr_en && !rst) dmem[data_addr[7:0]] <= wr_data;

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] sext8(input logic [7:0] v);
      return {{8{v[7]}}, v};
   endfunction

   task automatic clear_rom();
      for (int i = 0; i < 64; i++) rom[i] = 16'h0000;
   endtask

   task automatic fill_dmem();
      for (int i = 0; i < 256; i++) dmem[i] = 16'($urandom);
   endtask

   // R1: reset, check address, then align the model
   task automatic do_reset();
      rst = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk("R1", code_addr, 16'h0000);
      for (int i = 0; i < 16; i++) mr[i] = 16'h0000;
      for (int i = 0; i < 256; i++) mdm[i] = dmem[i];
      mflag  = 1'b0;
      pc_tag = "R2";
      rst    = 1'b0;
   endtask

   // compare the current cycle, then advance the model one instruction
   task automatic step();
      logic [15:0] ins, pc, nxt, val;
      logic [3:0]  op, a, b, c;
      logic        wr;
      pc  = mr[14];
      ins = rom[pc[6:1]];
      op  = ins[15:12]; a = ins[11:8]; b = ins[7:4]; c = ins[3:0];
      chk(pc_tag, code_addr, pc);
      chk("R5", {15'd0, wr_en}, {15'd0, op == 4'h2});
      if (op == 4'h2) begin
         chk(st_tag, data_addr, mr[b]);
         chk(st_tag, wr_data, mr[a]);
      end
      if (op == 4'h1) chk("R6", data_addr, mr[b]);
      nxt = pc + 16'd2; wr = 1'b0; val = 16'h0;
      pc_tag = "R2";
      case (op)
         4'hE: begin wr = 1'b1; val = {8'h00, ins[7:0]}; pc_tag = "R3"; end
         4'h3: begin wr = 1'b1; val = mr[b] + mr[c]; pc_tag = "R7"; end
         4'h1: begin wr = 1'b1; val = mdm[mr[b][7:0]]; pc_tag = "R6"; end
         4'h2: mdm[mr[b][7:0]] = mr[a];
         4'hC: begin mflag = (mr[a] == mr[b]); pc_tag = "R8"; end
         4'hD: begin if (mflag) nxt = pc + sext8(ins[7:0]); pc_tag = "R9"; end
         default: ;
      endcase
      mr[14] = nxt;
      if (wr) begin
         mr[a] = val;
         if (a == 4'd14) pc_tag = (op == 4'hE) ? "R4" : "R10";
      end
      @(negedge clk);
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   function automatic logic [15:0] rand_instr();
      logic [15:0] r;
      r = 16'($urandom);
      case ($urandom % 8)
         0: return 16'h0000;
         1: return {4'h1, r[11:0]};
         2: return {4'h2, r[11:0]};
         3: return {4'h3, r[11:0]};
         4: return {4'hC, r[11:0]};
         5: return {4'hD, r[11:0]};
         6: return {4'hE, r[11:0]};
         default: return {4'h4 + 4'(r[2:0]) + 4'(r[3] & r[2]), r[11:0]};
      endcase
   endfunction

   initial begin
      #(10 * 150000);
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      st_tag = "R5";

      // load/store/add/compare/branch/jump program
      clear_rom(); fill_dmem();
      rom[1] = 16'he02a; rom[2] = 16'he125; rom[3] = 16'h2010;
      rom[4] = 16'h1210; rom[5] = 16'h3322; rom[6] = 16'h2310;
      rom[7] = 16'hc020; rom[8] = 16'hde04; rom[10] = 16'hee00;
      do_reset();
      st_tag = "R6";
      run(9);
      chk("R7", dmem[16'h25], 16'h0054);
      chk("R9", code_addr, 16'h0014);
      run(1);
      chk("R4", code_addr, 16'h0000);

      // R11: operand r14 reads own address
      clear_rom(); fill_dmem();
      rom[0] = 16'he105; rom[1] = 16'h30ef; rom[2] = 16'h2010;
      do_reset(); st_tag = "R11";
      run(4);
      chk("R11", dmem[5], 16'h0002);

      // R3: zero extension of 0xFF
      clear_rom(); fill_dmem();
      rom[0] = 16'he107; rom[1] = 16'he2ff; rom[2] = 16'h2210;
      do_reset(); st_tag = "R3";
      run(4);
      chk("R3", dmem[7], 16'h00ff);

      // R7: doubling to 0x8000 then wrap to zero
      clear_rom(); fill_dmem();
      rom[0] = 16'he480;
      for (int i = 1; i <= 8; i++) rom[i] = 16'h3444;
      rom[9] = 16'h3544; rom[10] = 16'he109; rom[11] = 16'h2510;
      rom[12] = 16'he10a; rom[13] = 16'h2410;
      do_reset(); st_tag = "R7";
      run(15);
      chk("R7", dmem[9], 16'h0000);
      chk("R7", dmem[10], 16'h8000);

      // R8/R9: not-taken then taken branch
      clear_rom(); fill_dmem();
      rom[0] = 16'he001; rom[1] = 16'he102; rom[2] = 16'hc010;
      rom[3] = 16'hde06; rom[4] = 16'hc000; rom[5] = 16'hde04;
      rom[6] = 16'hee00;
      do_reset(); st_tag = "R8";
      run(4);
      chk("R8", code_addr, 16'h0008);
      run(2);
      chk("R9", code_addr, 16'h000e);

      // R10: load into PC, then add into PC
      clear_rom(); fill_dmem();
      dmem[16'h40] = 16'h0020;
      rom[0] = 16'he140; rom[1] = 16'h1e10; rom[16] = 16'h3e11;
      do_reset(); st_tag = "R10";
      run(2);
      chk("R10", code_addr, 16'h0020);
      run(1);
      chk("R10", code_addr, 16'h0080);

      // random programs against the model
      st_tag = "R5";
      for (int p = 0; p < 20; p++) begin
         for (int i = 0; i < 64; i++) rom[i] = rand_instr();
         fill_dmem();
         do_reset();
         run(300);
      end

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule